// File: doc/BRIEF.md
# Sentinel-Terminated Serial Byte Transmitter

This block turns one byte into an asynchronous serial frame on a single line. The frame is a low start bit, the eight payload bits with the least significant bit first, and a high stop bit. The block is clocked at exactly the bit rate, so every clock cycle puts one bit period on the line. A request pulse, sampled while the block is idle, captures the byte and starts the frame. Until the frame ends, the ready flag is low and further requests have no effect.

The frame sits in one ten-bit shift register. The register moves one place toward the line output per cycle and fills with zeros from the far end. No bit counter exists. The end of a frame is recognised when only the stop bit is left, which gives the pattern with a single one in the position that drives the line. That pattern is also the reset and idle content, so the line rests high whenever nothing is being sent. A caller that keeps the request high gets back-to-back frames, each with a stop bit one bit period long.

Top module: `sertx_top`

## Requirements
- R1: While reset is high (synchronous, active high), and in the first cycle after reset, `tx_line` is 1 and `tx_ready` is 1.
- R2: While `tx_ready` is 1, `tx_line` is 1. Without a request the block stays idle, with `tx_ready` high.
- R3: When a clock edge samples `tx_start`=1 while `tx_ready`=1, `tx_line` is 0 (the start bit) and `tx_ready` is 0 from the next cycle.
- R4: In the 2nd to 9th cycles after the load, `tx_line` carries bits 0 to 7 of the byte sampled at the load edge, least significant bit first.
- R5: In the 10th cycle after the load, `tx_line` is 1 (the stop bit) and `tx_ready` is 1 again.
- R6: A request given while `tx_ready` is 0 is ignored. The frame in progress keeps its data and timing, and no extra frame follows.
- R7: `tx_ready` stays low for exactly 9 consecutive cycles per frame for every byte value, including 8'h00, 8'hFF, 8'h01 and 8'h80.
- R8: With `tx_start` held high, a new frame loads in the stop-bit cycle, so successive frames begin exactly 10 cycles apart, and each loads the byte present at its own load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock running at the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Byte to send, sampled at the load edge |
| tx_start | input | 1 | Send request, honoured only while ready |
| tx_line | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | High when idle and able to accept a byte |

## Verification
On every cycle, the assertions check four things: a high line whenever the block is idle, the start bit and busy flag after each accepted request, each payload bit against the byte captured at the load, and a busy window of exactly nine cycles that ends on the stop bit. Other properties only the bench scenarios can show. These are that requests during a frame leave no trace and produce no phantom frame, that all-zero and all-one bytes end correctly, that a held request gives a ten-cycle frame cadence, and that a reset in the middle of a frame returns the line to idle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    parameter int DATA_W = 8;
    localparam int FRAME_W = DATA_W + 2;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [DATA_W-1:0]  byte_t;

    typedef struct packed {
        logic  stop_bit;
        byte_t payload;
        logic  start_bit;
    } frame_fields_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    localparam frame_t END_MARK = frame_t'(1);

    function automatic frame_t pack_frame(input byte_t d);
        frame_fields_t f;
        f.stop_bit  = 1'b1;
        f.payload   = d;
        f.start_bit = 1'b0;
        return frame_t'(f);
    endfunction

    function automatic frame_t advance(input frame_t f);
        return {1'b0, f[FRAME_W-1:1]};
    endfunction

endpackage

// File: rtl/sertx_frame_reg.sv
module sertx_frame_reg
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   shift,
    input  byte_t  data,
    output frame_t frame,
    output logic   line
);

    frame_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= END_MARK;
        end else if (load) begin
            q <= pack_frame(data);
        end else if (shift) begin
            q <= advance(q);
        end
    end

    assign frame = q;
    assign line  = q[0];

endmodule

// File: rtl/sertx_mark_detect.sv
module sertx_mark_detect
    import sertx_pkg::*;
(
    input  frame_t frame,
    output phase_e phase
);

    always_comb begin
        if (frame == END_MARK) phase = PH_IDLE;
        else                   phase = PH_SEND;
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    output logic              tx_line,
    output logic              tx_ready
);

    frame_t frame;
    phase_e phase;
    logic   do_load;
    logic   do_shift;

    always_comb begin
        do_load  = 1'b0;
        do_shift = 1'b0;
        case (phase)
            PH_IDLE: do_load  = tx_start;
            PH_SEND: do_shift = 1'b1;
            default: do_shift = 1'b0;
        endcase
    end

    sertx_frame_reg u_freg (
        .clk   (clk),
        .rst   (rst),
        .load  (do_load),
        .shift (do_shift),
        .data  (tx_data),
        .frame (frame),
        .line  (tx_line)
    );

    sertx_mark_detect u_mark (
        .frame (frame),
        .phase (phase)
    );

    assign tx_ready = (phase == PH_IDLE);

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] data,
    input logic              start,
    input logic              line,
    input logic              ready
);

    localparam int CW = $clog2(FRAME_W + 1);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] lat;
    logic [CW-1:0]     off;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lat <= '0;
        end else if (ready && start) begin
            cnt <= CW'(1);
            lat <= data;
        end else if (cnt == CW'(FRAME_W)) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign off = cnt - CW'(2);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (ready && line));

    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        ready |-> line);

    p_start_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (!line && !ready));

    p_data_lsb_first_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt >= CW'(2) && cnt <= CW'(FRAME_W - 1)) |-> (line == lat[off[IW-1:0]]));

    p_stop_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(FRAME_W)) |-> (line && ready));

    p_busy_window_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt >= CW'(1) && cnt <= CW'(FRAME_W - 1)) |-> !ready);

endmodule

bind sertx_top sertx_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .data  (tx_data),
    .start (tx_start),
    .line  (tx_line),
    .ready (tx_ready)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic       start = 1'b0;
    logic       line;
    logic       ready;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sertx_top u0 (
        .clk      (clk),
        .rst      (rst),
        .tx_data  (din),
        .tx_start (start),
        .tx_line  (line),
        .tx_ready (ready)
    );

    // behavioural reference: queue of bits still to be driven
    bit    q[$];
    bit    exp_line  = 1'b1;
    bit    exp_ready = 1'b1;
    string tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            exp_line = 1'b1;
            tag = "R1";
        end else if (q.size() == 0) begin
            if (start) begin
                for (int i = 0; i < 8; i++) q.push_back(din[i]);
                q.push_back(1'b1);
                exp_line = 1'b0;
                tag = "R3";
            end else begin
                exp_line = 1'b1;
                tag = "R2";
            end
        end else begin
            exp_line = q.pop_front();
            if (start)             tag = "R6";
            else if (q.size() == 0) tag = "R5";
            else                    tag = "R4";
        end
        exp_ready = (q.size() == 0);
    end

    task automatic check(input string t, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison plus run-length checks for R7 and R8
    int  low_run  = 0;
    int  high_run = 0;
    int  since_fall = -1;
    bit  prev_ready = 1'b1;

    always @(negedge clk) begin
        check(tag, int'(line), int'(exp_line), "tx_line");
        check(tag, int'(ready), int'(exp_ready), "tx_ready");
        if (rst) begin
            low_run = 0; high_run = 0; since_fall = -1; prev_ready = 1'b1;
        end else begin
            if (since_fall >= 0) since_fall++;
            if (prev_ready && !ready) begin
                if (high_run == 1 && since_fall >= 0)
                    check("R8", since_fall, 10, "frame spacing");
                since_fall = 0;
            end
            if (!prev_ready && ready) check("R7", low_run, 9, "busy length");
            if (ready) begin high_run++; low_run = 0; end
            else       begin low_run++;  high_run = 0; end
            prev_ready = ready;
        end
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        din = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(5);                                // R1, R2
        send(8'hA5);                            // R3, R4, R5
        idle(3);
        send(8'h00);                            // R7 all zeros
        send(8'hFF);                            // R7 all ones
        idle(2);
        send(8'h01);
        send(8'h80);
        idle(2);
        // R6: requests with other data during a frame
        @(negedge clk); din = 8'h3C; start = 1'b1;
        @(negedge clk); start = 1'b0; din = 8'hC3;
        idle(2); start = 1'b1;
        @(negedge clk); start = 1'b0;
        idle(3); start = 1'b1; din = 8'h99;
        idle(2); start = 1'b0;
        while (!ready) @(negedge clk);
        idle(4);                                // R6 no extra frame
        // R8: held request, data changes per frame
        @(negedge clk); din = 8'h5A; start = 1'b1;
        idle(10); din = 8'h96;
        idle(10); din = 8'h0F;
        idle(9); start = 1'b0;
        while (!ready) @(negedge clk);
        idle(3);
        // R1: reset mid-frame
        @(negedge clk); din = 8'h77; start = 1'b1;
        @(negedge clk); start = 1'b0;
        idle(3); rst = 1'b1;
        idle(2); rst = 1'b0;
        idle(3);
        send(8'hE1);
        idle(3);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule